// File: doc/BRIEF.md
# Flat-Nested Two-Dimensional Page Walker

This block resolves a 48-bit guest virtual address to a system physical address for a processor that runs guest machines. The guest keeps a four-level page table. Every guest physical address that the walk meets must itself be mapped to system memory. That covers the guest root pointer, the three inner table pointers and the final guest frame. Here that mapping is one indexed read of a single-level table, where a layered nested table would need four reads. A complete walk therefore costs nine 64-bit entry reads instead of twenty-four.

A translation request carries the guest virtual address, the guest physical address of the guest root table and the system base of the flat nested table. The walker takes one request at a time. It reads entries through a valid/ready memory port that may stall the request or the response for any number of cycles. It finishes with a one-cycle success pulse that carries the system physical address, or with a one-cycle fault pulse. The fault pulse says whether a guest entry or a nested entry was absent, and at which level.

Top module: `flat_nested_walker`

## Requirements
- R1: After reset `req_ready` is 1 and no output pulse or memory request is active. `req_ready` drops in the cycle after a request is accepted and stays 0 until the cycle that shows `done_valid` or `fault_valid`. It is 1 in that cycle.
- R2: A nested read for a guest physical address uses address `nested_base + gpn*8`, where gpn is bits 31:12 of the guest physical address. The low 12 bits of the root pointer are ignored.
- R3: A guest read at level L (4 down to 1) uses address `table_frame*4096 + idx*8`, where idx is guest virtual address bits 12+9*(L-1) up to 20+9*(L-1). table_frame is the system frame returned by the nested read just before it.
- R4: Reads alternate nested, guest, nested, and so on: root nested, L4, nested, L3, nested, L2, nested, L1, then the final nested read. A successful walk issues exactly nine reads.
- R5: Bit 0 of every entry is the present bit. A nested entry gives the system frame in bits 51:12. A guest entry gives the next guest page number in bits 31:12. All other entry bits are ignored.
- R6: On success `done_valid` pulses for one cycle and `done_spa` is the final system frame joined with guest virtual address bits 11:0.
- R7: A guest entry with bit 0 clear ends the walk with a `fault_valid` pulse. `fault_nested` is 0 and `fault_level` is the guest level, 4 to 1. No further reads are issued.
- R8: A nested entry with bit 0 clear ends the walk with `fault_nested` = 1. `fault_level` is the guest level of the table the address pointed to: 4 for the root, then 3, 2, 1, and 0 for the final data frame. No further reads are issued.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address hold. `mem_rsp_ready` is 1 only while a response is awaited, and never while a request is being offered.
- R10: `done_valid` and `fault_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_valid | input | 1 | translation request offered |
| req_ready | output | 1 | walker idle, request accepted |
| req_gva | input | 48 | guest virtual address |
| req_groot | input | 32 | guest physical address of the guest root table |
| req_nbase | input | 52 | system base of the flat nested table |
| done_valid | output | 1 | one-cycle success pulse |
| done_spa | output | 52 | translated system physical address |
| fault_valid | output | 1 | one-cycle fault pulse |
| fault_nested | output | 1 | 1: nested entry absent, 0: guest entry absent |
| fault_level | output | 3 | level of the absent entry |
| mem_req_valid | output | 1 | entry read offered |
| mem_req_ready | input | 1 | memory accepts read |
| mem_req_addr | output | 52 | byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | entry data returned |
| mem_rsp_ready | output | 1 | walker takes the data |
| mem_rsp_data | input | 64 | entry contents |

## Verification
The walker is driven with full walks whose table entries carry random bits outside the fields that are used. It also sees walks with the present bit cleared at each of the nine steps in turn. The first separates field extraction from stray bits. The second separates guest from nested faults and pins the level reported at every depth. Each of these patterns runs once with a memory that always answers at once and once with random request stalls and response delays. That separates correct handshake holding from reliance on fixed latency. Random virtual addresses, together with all-zero and all-one index directed cases, check that each level takes its own index field and that the offset reaches the result.

// File: rtl/fnw_pkg.sv
package fnw_pkg;
    localparam int VA_W    = 48;
    localparam int GPA_W   = 32;
    localparam int PA_W    = 52;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 9;
    localparam int LEVELS  = 4;
    localparam int PTE_W   = 64;
    localparam int PTE_SH  = 3;
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int GPN_W   = GPA_W - OFF_W;
    localparam int N_STEPS = 2 * LEVELS + 1;
    localparam int STEP_W  = $clog2(N_STEPS);
    localparam int LVL_W   = $clog2(LEVELS + 1);
    localparam int LAST_STEP = N_STEPS - 1;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2
    } wk_state_e;

    typedef struct packed {
        wk_state_e             st;
        logic [STEP_W-1:0]     step;
        logic [VA_W-1:0]       gva;
        logic [PA_W-1:0]       nbase;
        logic [GPN_W-1:0]      gpn;
        logic [FRAME_W-1:0]    tframe;
        logic                  done;
        logic                  fault;
        logic                  f_nested;
        logic [LVL_W-1:0]      f_level;
        logic [PA_W-1:0]       spa;
    } wk_reg_t;
endpackage

// File: rtl/fnw_addr_gen.sv
module fnw_addr_gen
    import fnw_pkg::*;
(
    input  logic [STEP_W-1:0]  step,
    input  logic [VA_W-1:0]    gva,
    input  logic [PA_W-1:0]    nbase,
    input  logic [GPN_W-1:0]   gpn,
    input  logic [FRAME_W-1:0] tframe,
    output logic [PA_W-1:0]    addr,
    output logic               nested,
    output logic [LVL_W-1:0]   level
);
    localparam int TAB_N = 2 ** LVL_W;

    logic [IDX_W-1:0] idx_tab [TAB_N];
    logic             unused_off;

    assign unused_off = ^gva[OFF_W-1:0];

    generate
        for (genvar l = 0; l < TAB_N; l++) begin : g_idx
            if (l >= 1 && l <= LEVELS) begin : g_used
                assign idx_tab[l] = gva[OFF_W + IDX_W*(l-1) +: IDX_W];
            end else begin : g_zero
                assign idx_tab[l] = '0;
            end
        end
    endgenerate

    always_comb begin
        nested = ~step[0];
        level  = LVL_W'(LEVELS) - LVL_W'(step >> 1);
        if (nested) begin
            addr = nbase + PA_W'({gpn, {PTE_SH{1'b0}}});
        end else begin
            addr = {tframe, {OFF_W{1'b0}}} + PA_W'({idx_tab[level], {PTE_SH{1'b0}}});
        end
    end
endmodule

// File: rtl/fnw_pte_dec.sv
module fnw_pte_dec
    import fnw_pkg::*;
(
    input  logic [PTE_W-1:0]   pte,
    output logic               present,
    output logic [FRAME_W-1:0] frame,
    output logic [GPN_W-1:0]   gpn
);
    logic unused_bits;

    assign present     = pte[0];
    assign frame       = pte[OFF_W +: FRAME_W];
    assign gpn         = pte[OFF_W +: GPN_W];
    assign unused_bits = ^{pte[PTE_W-1:PA_W], pte[OFF_W-1:1]};
endmodule

// File: rtl/flat_nested_walker.sv
module flat_nested_walker
    import fnw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [47:0]       req_gva,
    input  logic [31:0]       req_groot,
    input  logic [51:0]       req_nbase,
    output logic              done_valid,
    output logic [51:0]       done_spa,
    output logic              fault_valid,
    output logic              fault_nested,
    output logic [2:0]        fault_level,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [51:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [63:0]       mem_rsp_data
);
    wk_reg_t r_q, r_d;

    logic               cur_nested;
    logic [LVL_W-1:0]   cur_level;
    logic               pte_present;
    logic [FRAME_W-1:0] pte_frame;
    logic [GPN_W-1:0]   pte_gpn;
    logic               unused_root;

    assign unused_root = ^req_groot[OFF_W-1:0];

    fnw_addr_gen u_addr (
        .step   (r_q.step),
        .gva    (r_q.gva),
        .nbase  (r_q.nbase),
        .gpn    (r_q.gpn),
        .tframe (r_q.tframe),
        .addr   (mem_req_addr),
        .nested (cur_nested),
        .level  (cur_level)
    );

    fnw_pte_dec u_dec (
        .pte     (mem_rsp_data),
        .present (pte_present),
        .frame   (pte_frame),
        .gpn     (pte_gpn)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        case (r_q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    r_d.st    = WK_ISSUE;
                    r_d.step  = '0;
                    r_d.gva   = req_gva;
                    r_d.nbase = req_nbase;
                    r_d.gpn   = req_groot[GPA_W-1:OFF_W];
                end
            end
            WK_ISSUE: begin
                if (mem_req_ready) begin
                    r_d.st = WK_WAIT;
                end
            end
            WK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_present) begin
                        r_d.st       = WK_IDLE;
                        r_d.fault    = 1'b1;
                        r_d.f_nested = cur_nested;
                        r_d.f_level  = cur_level;
                    end else if (r_q.step == STEP_W'(LAST_STEP)) begin
                        r_d.st   = WK_IDLE;
                        r_d.done = 1'b1;
                        r_d.spa  = {pte_frame, r_q.gva[OFF_W-1:0]};
                    end else begin
                        r_d.st   = WK_ISSUE;
                        r_d.step = STEP_W'(r_q.step + 1'b1);
                        if (cur_nested) begin
                            r_d.tframe = pte_frame;
                        end else begin
                            r_d.gpn = pte_gpn;
                        end
                    end
                end
            end
            default: r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == WK_IDLE);
    assign mem_req_valid = (r_q.st == WK_ISSUE);
    assign mem_rsp_ready = (r_q.st == WK_WAIT);
    assign done_valid    = r_q.done;
    assign done_spa      = r_q.spa;
    assign fault_valid   = r_q.fault;
    assign fault_nested  = r_q.f_nested;
    assign fault_level   = r_q.f_level;

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    p_ready_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |-> req_ready);
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.step <= STEP_W'(LAST_STEP));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && mem_rsp_ready));
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));
endmodule

// File: tb/sim_flat_nested_walker.sv
module sim_flat_nested_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_gva = '0;
    logic [31:0] req_groot = '0;
    logic [51:0] req_nbase = '0;
    logic        done_valid;
    logic [51:0] done_spa;
    logic        fault_valid;
    logic        fault_nested;
    logic [2:0]  fault_level;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    flat_nested_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_gva(req_gva), .req_groot(req_groot), .req_nbase(req_nbase),
        .done_valid(done_valid), .done_spa(done_spa),
        .fault_valid(fault_valid), .fault_nested(fault_nested), .fault_level(fault_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [63:0] mem [logic [51:0]];
    logic [51:0] log_addr [16];
    int          log_n = 0;
    bit          stall_mode = 0;
    bit          done_seen = 0, fault_seen = 0, both_seen = 0;
    logic [51:0] got_spa;
    logic        got_nested;
    logic [2:0]  got_level;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // memory responder and output monitor
    initial begin
        bit          hs_req = 0, hs_rsp = 0, pend = 0, prev_wait = 0;
        logic [51:0] cap_addr = '0, pend_addr = '0, prev_addr = '0;
        int          dly = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
                finish_run();
            end
            if (hs_req) begin
                if (log_n < 16) log_addr[log_n] = cap_addr;
                log_n++;
                pend = 1; pend_addr = cap_addr;
                dly = stall_mode ? int'($urandom % 4) : 0;
            end
            if (hs_rsp) begin
                mem_rsp_valid = 1'b0;
                pend = 0;
            end
            mem_req_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
            if (pend && !mem_rsp_valid) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
                end else begin
                    dly--;
                end
            end
            #1;
            if (prev_wait) begin
                // R9: stalled request holds its address
                chk(mem_req_valid && mem_req_addr == prev_addr, "R9 request hold",
                    64'(mem_req_addr), 64'(prev_addr));
                // R9: response not accepted while a request is offered
                chk(!(mem_req_valid && mem_rsp_ready), "R9 rsp_ready during request",
                    64'(mem_rsp_ready), 64'h0);
            end
            prev_wait = mem_req_valid && !mem_req_ready;
            prev_addr = mem_req_addr;
            hs_req    = mem_req_valid && mem_req_ready;
            cap_addr  = mem_req_addr;
            hs_rsp    = mem_rsp_valid && mem_rsp_ready;
            if (done_valid) begin done_seen = 1; got_spa = done_spa; end
            if (fault_valid) begin fault_seen = 1; got_nested = fault_nested; got_level = fault_level; end
            if (done_valid && fault_valid) both_seen = 1;
        end
    end

    // one walk: fstep is the step whose entry lacks the present bit (9 = none)
    task automatic run_walk(input logic [47:0] gva, input logic [31:0] groot,
                            input logic [51:0] nbase, input int fstep);
        logic [19:0] gpn [5];
        logic [39:0] sfr [5];
        logic [51:0] exp_addr [9];
        int          exp_n;
        int          wait_c;
        mem.delete();
        gpn[0] = groot[31:12];
        for (int k = 1; k < 5; k++) gpn[k] = {4'(k), 16'($urandom)};
        for (int k = 0; k < 5; k++) sfr[k] = {4'(k + 1), 4'($urandom), 32'($urandom)};
        for (int k = 0; k < 5; k++) begin
            logic [63:0] ent;
            exp_addr[2*k] = nbase + 52'({gpn[k], 3'b000});
            ent = {12'($urandom), sfr[k], 11'($urandom), 1'(2*k != fstep)};
            mem[exp_addr[2*k]] = ent;
            if (k < 4) begin
                int          lvl = 4 - k;
                logic [8:0]  idx = gva[12 + 9*(lvl-1) +: 9];
                exp_addr[2*k+1] = {sfr[k], 12'h000} + 52'({idx, 3'b000});
                ent = {32'($urandom), gpn[k+1], 11'($urandom), 1'(2*k+1 != fstep)};
                mem[exp_addr[2*k+1]] = ent;
            end
        end
        exp_n = (fstep < 9) ? fstep + 1 : 9;
        log_n = 0; done_seen = 0; fault_seen = 0; both_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_gva = gva; req_groot = groot; req_nbase = nbase;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(!req_ready, "R1 ready low after accept", 64'(req_ready), 64'h0);
        wait_c = 0;
        while (!(done_seen || fault_seen) && wait_c < 400) begin @(negedge clk); #2; wait_c++; end
        chk(req_ready, "R1 ready back at end", 64'(req_ready), 64'h1);
        repeat (8) @(negedge clk);
        #2;
        chk(log_n == exp_n, (fstep < 9) ? "R7/R8 no reads after fault" : "R4 nine reads",
            64'(log_n), 64'(exp_n));
        for (int s = 0; s < exp_n && s < log_n; s++) begin
            chk(log_addr[s] == exp_addr[s], (s % 2 == 0) ? "R2 nested address" : "R3 guest address",
                64'(log_addr[s]), 64'(exp_addr[s]));
        end
        chk(!both_seen, "R10 done and fault together", 64'(both_seen), 64'h0);
        if (fstep >= 9) begin
            chk(done_seen && !fault_seen, "R6 done pulse", 64'({done_seen, fault_seen}), 64'h2);
            chk(got_spa == {sfr[4], gva[11:0]}, "R6/R5 result address",
                64'(got_spa), 64'({sfr[4], gva[11:0]}));
        end else begin
            chk(fault_seen && !done_seen, "R7/R8 fault pulse", 64'({done_seen, fault_seen}), 64'h1);
            chk(got_nested == (fstep % 2 == 0), (fstep % 2 == 0) ? "R8 nested kind" : "R7 guest kind",
                64'(got_nested), 64'(fstep % 2 == 0));
            chk(got_level == 3'(4 - fstep / 2), (fstep % 2 == 0) ? "R8 level" : "R7 level",
                64'(got_level), 64'(4 - fstep / 2));
        end
    endtask

    function automatic logic [51:0] rnd_nbase();
        return {4'hF, 8'($urandom), 20'($urandom), 20'h0};
    endfunction

    function automatic logic [47:0] rnd_gva();
        return {16'($urandom), 32'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(req_ready, "R1 reset ready", 64'(req_ready), 64'h1);
        chk(!mem_req_valid, "R1 reset no read", 64'(mem_req_valid), 64'h0);
        chk(!done_valid && !fault_valid, "R1 reset no pulse", 64'({done_valid, fault_valid}), 64'h0);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            stall_mode = bit'(m);
            // R4 R6 directed success with offset bits in root ignored (R2)
            run_walk(48'h0000_0000_0ABC, 32'h0123_4FFF, rnd_nbase(), 9);
            run_walk(48'hFFFF_FFFF_FFFF, 32'h0FFF_F000, rnd_nbase(), 9);
            // R7 R8 fault at every step
            for (int f = 0; f < 9; f++) begin
                run_walk(rnd_gva(), {4'h0, 28'($urandom)}, rnd_nbase(), f);
            end
        end
        // random mix with random stalls
        for (int t = 0; t < 40; t++) begin
            stall_mode = bit'($urandom % 2);
            run_walk(rnd_gva(), {4'h0, 28'($urandom)}, rnd_nbase(),
                     ($urandom % 2 == 0) ? 9 : int'($urandom % 9));
        end
        finish_run();
    end
endmodule